// File: doc/BRIEF.md
# Slot Timing Synchronization Correlator

This block locates the slot boundary of a spread-spectrum downlink. It correlates the received complex baseband stream against a real-valued synchronization code. In every slot that code is sent once, over the chips at the head of the slot. The input arrives oversampled, and the block keeps one sample per chip. A tapped delay line as long as the code produces one correlation per chip. Its magnitude metric is added into an energy bin for the chip offset that correlation stands for.

After a configured number of slots, the block scans all bins. It reports the offset with the most energy as the chip position where the code begins within the slot. A search begins on a `start` pulse. The code is loaded as a bit vector, in which each bit selects +1 or −1. The result is presented with a one-cycle valid strobe.

With the default parameters the slot is 2560 chips long and the code is 256 chips. There are 4 samples per chip, 15 slots per search, and the inputs are 12-bit signed I and Q.

Top module: `slot_timing_sync`

## Requirements
- R1: After reset, `res_vld` is low and no search is active until `start` is pulsed.
- R2: A `start` pulse begins a fresh search in any state. It clears the energy bins, the delay line, the chip position and the decimation phase. A search that was running is abandoned and never reports. A sample presented in the same cycle as `start` is not taken.
- R3: Samples are taken only while a search is running and `in_vld` is high. Samples presented at other times change neither the result nor its timing.
- R4: Of each group of `SPC` taken samples, only the first is kept as the chip. The other `SPC`−1 samples have no effect on the result.
- R5: `code_in` is captured when `code_we` is high. Bit j is code chip j, with bit 0 the first chip sent. A 1 stands for +1 and a 0 for −1.
- R6: For each kept chip k, counted from 0 at `start`, the I sum and the Q sum are each formed as Σj c[j]·x[k−CODE_LEN+1+j]. Chips from before `start` count as zero. The metric |ΣI|+|ΣQ| is added to bin (k−CODE_LEN+1) mod SLOT_LEN.
- R7: A search ends once NSLOT×SPC×SLOT_LEN samples have been taken. `res_vld` rises SLOT_LEN+3 cycles after the cycle in which the final sample is presented.
- R8: `res_idx` is the bin with the largest energy. On a tie the lowest index wins, so an all-zero input reports 0.
- R9: `res_vld` is high for exactly one cycle per completed search. No further result appears until the next `start`.
- R10: Full-scale inputs over NSLOT_MAX slots neither overflow the correlator sums nor wrap the energy bins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search (aborts any search in progress) |
| code_we | input | 1 | Load enable for the synchronization code |
| code_in | input | CODE_LEN | Code chips, bit j = chip j, 1 → +1, 0 → −1 |
| in_vld | input | 1 | Input sample qualifier |
| in_i | input | IN_W | Received in-phase sample, signed |
| in_q | input | IN_W | Received quadrature sample, signed |
| res_vld | output | 1 | One-cycle strobe for a new timing result |
| res_idx | output | clog2(SLOT_LEN) | Chip offset where the code starts in the slot |

## Verification
The bench builds the block with 3 samples per chip, 3 slots per search, 40-chip slots and an 8-chip code. A full search then takes a few hundred cycles, so several searches fit in one run. These include a code placement that wraps across the slot boundary, gaps in `in_vld`, an aborted search and full-scale input. Because the slot is only five code lengths long, the zero-filled start of the delay line and the wrap of the bin index both show up in every search. Using 3 samples per chip, with random values on the samples that are skipped, exposes any error in which sample is kept.

// File: rtl/slot_sync_pkg.sv
`timescale 1ns/1ps
package slot_sync_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FLUSH = 2'd2,
      ST_SCAN  = 2'd3
   } sts_state_e;

   // cycles between the last taken sample and the first bin read:
   // decimator register + delay-line register ahead of the bin write
   localparam int FLUSH_CYC = 2;

endpackage

// File: rtl/sts_decim.sv
`timescale 1ns/1ps
module sts_decim #(
   parameter int SPC  = 4,
   parameter int IN_W = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   take,
   input  logic signed [IN_W-1:0] in_i,
   input  logic signed [IN_W-1:0] in_q,
   output logic                   chip_vld,
   output logic signed [IN_W-1:0] chip_i,
   output logic signed [IN_W-1:0] chip_q
);

   generate
      if (SPC == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chip_vld <= 1'b0;
               chip_i   <= '0;
               chip_q   <= '0;
            end else if (clr) begin
               chip_vld <= 1'b0;
            end else begin
               chip_vld <= take;
               if (take) begin
                  chip_i <= in_i;
                  chip_q <= in_q;
               end
            end
         end
      end else begin : g_phase
         localparam int PH_W = $clog2(SPC);
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(SPC - 1);
         logic [PH_W-1:0] phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase    <= '0;
               chip_vld <= 1'b0;
               chip_i   <= '0;
               chip_q   <= '0;
            end else if (clr) begin
               phase    <= '0;
               chip_vld <= 1'b0;
            end else begin
               chip_vld <= take && (phase == '0);
               if (take) begin
                  if (phase == '0) begin
                     chip_i <= in_i;
                     chip_q <= in_q;
                  end
                  phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sts_corr.sv
`timescale 1ns/1ps
module sts_corr #(
   parameter int IN_W     = 12,
   parameter int CODE_LEN = 256,
   parameter int SLOT_LEN = 2560,
   parameter int CORR_W   = 21,
   parameter int MET_W    = 22,
   parameter int IDX_W    = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   chip_vld,
   input  logic signed [IN_W-1:0] chip_i,
   input  logic signed [IN_W-1:0] chip_q,
   input  logic [CODE_LEN-1:0]    code,
   output logic                   met_vld,
   output logic [IDX_W-1:0]       met_idx,
   output logic [MET_W-1:0]       metric
);

   localparam int LAG = CODE_LEN - 1;
   localparam logic [IDX_W-1:0] POS_LAST = IDX_W'(SLOT_LEN - 1);
   localparam logic [IDX_W-1:0] LAG_V    = IDX_W'(LAG);
   localparam logic [IDX_W-1:0] WRAP_V   = IDX_W'(SLOT_LEN - LAG);

   // tap 0 holds the oldest chip, tap CODE_LEN-1 the newest
   logic signed [IN_W-1:0]   tap_i  [CODE_LEN];
   logic signed [IN_W-1:0]   tap_q  [CODE_LEN];
   logic signed [CORR_W-1:0] term_i [CODE_LEN];
   logic signed [CORR_W-1:0] term_q [CODE_LEN];
   logic signed [CORR_W-1:0] sum_i, sum_q;
   logic [CORR_W-1:0]        mag_i, mag_q;
   logic [IDX_W-1:0]         pos, off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < CODE_LEN; j++) begin
            tap_i[j] <= '0;
            tap_q[j] <= '0;
         end
      end else if (clr) begin
         for (int j = 0; j < CODE_LEN; j++) begin
            tap_i[j] <= '0;
            tap_q[j] <= '0;
         end
      end else if (chip_vld) begin
         for (int j = 0; j < CODE_LEN - 1; j++) begin
            tap_i[j] <= tap_i[j+1];
            tap_q[j] <= tap_q[j+1];
         end
         tap_i[CODE_LEN-1] <= chip_i;
         tap_q[CODE_LEN-1] <= chip_q;
      end
   end

   // each tap either adds or subtracts its chip: no multipliers
   genvar gj;
   generate
      for (gj = 0; gj < CODE_LEN; gj++) begin : g_term
         assign term_i[gj] = code[gj] ? CORR_W'(tap_i[gj]) : -CORR_W'(tap_i[gj]);
         assign term_q[gj] = code[gj] ? CORR_W'(tap_q[gj]) : -CORR_W'(tap_q[gj]);
      end
   endgenerate

   always_comb begin
      sum_i = '0;
      sum_q = '0;
      for (int j = 0; j < CODE_LEN; j++) begin
         sum_i = sum_i + term_i[j];
         sum_q = sum_q + term_q[j];
      end
   end

   assign mag_i  = sum_i[CORR_W-1] ? CORR_W'(-sum_i) : CORR_W'(sum_i);
   assign mag_q  = sum_q[CORR_W-1] ? CORR_W'(-sum_q) : CORR_W'(sum_q);
   assign metric = MET_W'(mag_i) + MET_W'(mag_q);

   // bin of the chip entering now: where its window of CODE_LEN chips began
   assign off = (pos >= LAG_V) ? pos - LAG_V : pos + WRAP_V;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= '0;
         met_vld <= 1'b0;
         met_idx <= '0;
      end else if (clr) begin
         pos     <= '0;
         met_vld <= 1'b0;
      end else begin
         met_vld <= chip_vld;
         if (chip_vld) begin
            met_idx <= off;
            pos     <= (pos == POS_LAST) ? '0 : pos + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sts_accum.sv
`timescale 1ns/1ps
module sts_accum #(
   parameter int SLOT_LEN = 2560,
   parameter int MET_W    = 22,
   parameter int ACC_W    = 31,
   parameter int IDX_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [MET_W-1:0] wr_val,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ACC_W-1:0] rd_val
);

   logic [ACC_W-1:0] bin [SLOT_LEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < SLOT_LEN; b++) bin[b] <= '0;
      end else if (clr) begin
         for (int b = 0; b < SLOT_LEN; b++) bin[b] <= '0;
      end else if (wr_en) begin
         bin[wr_idx] <= bin[wr_idx] + ACC_W'(wr_val);
      end
   end

   assign rd_val = bin[rd_idx];

endmodule

// File: rtl/sts_peak.sv
`timescale 1ns/1ps
module sts_peak #(
   parameter int SLOT_LEN = 2560,
   parameter int ACC_W    = 31,
   parameter int IDX_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [ACC_W-1:0] rd_val,
   output logic [IDX_W-1:0] rd_idx,
   output logic             last,
   output logic             res_vld,
   output logic [IDX_W-1:0] res_idx
);

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOT_LEN - 1);

   logic [ACC_W-1:0] best;
   logic [IDX_W-1:0] best_idx;
   logic             take_new;

   assign last     = en && (rd_idx == IDX_LAST);
   // strictly greater: an equal later bin never displaces the earlier one
   assign take_new = (rd_idx == '0) || (rd_val > best);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_idx   <= '0;
         best     <= '0;
         best_idx <= '0;
         res_vld  <= 1'b0;
         res_idx  <= '0;
      end else if (clr) begin
         rd_idx   <= '0;
         best     <= '0;
         best_idx <= '0;
         res_vld  <= 1'b0;
      end else begin
         res_vld <= last;
         if (en) begin
            if (take_new) begin
               best     <= rd_val;
               best_idx <= rd_idx;
            end
            rd_idx <= last ? '0 : rd_idx + 1'b1;
         end
         if (last) res_idx <= take_new ? rd_idx : best_idx;
      end
   end

endmodule

// File: rtl/slot_timing_sync.sv
`timescale 1ns/1ps
module slot_timing_sync
   import slot_sync_pkg::*;
#(
   parameter int SPC       = 4,
   parameter int NSLOT     = 15,
   parameter int NSLOT_MAX = 500,
   parameter int SLOT_LEN  = 2560,
   parameter int CODE_LEN  = 256,
   parameter int IN_W      = 12,
   localparam int IDX_W    = $clog2(SLOT_LEN)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   code_we,
   input  logic [CODE_LEN-1:0]    code_in,
   input  logic                   in_vld,
   input  logic signed [IN_W-1:0] in_i,
   input  logic signed [IN_W-1:0] in_q,
   output logic                   res_vld,
   output logic [IDX_W-1:0]       res_idx
);

   localparam int CORR_W = IN_W + $clog2(CODE_LEN) + 1;
   localparam int MET_W  = CORR_W + 1;
   localparam int ACC_W  = MET_W + $clog2(NSLOT_MAX + 1);
   localparam int TOTAL  = NSLOT * SPC * SLOT_LEN;
   localparam int CNT_W  = $clog2(TOTAL + 1);
   localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(TOTAL - 1);
   localparam logic [1:0]       FLUSH_LAST = 2'(FLUSH_CYC - 1);

   if (SPC < 1 || SPC > 32) begin : g_bad_spc
      $error("slot_timing_sync: SPC must lie in 1..32");
   end
   if (NSLOT < 2 || NSLOT > NSLOT_MAX) begin : g_bad_nslot
      $error("slot_timing_sync: NSLOT must lie in 2..NSLOT_MAX");
   end
   if (SLOT_LEN < CODE_LEN || CODE_LEN < 2) begin : g_bad_len
      $error("slot_timing_sync: need 2 <= CODE_LEN <= SLOT_LEN");
   end

   sts_state_e          state;
   logic [CNT_W-1:0]    scnt;
   logic [1:0]          fcnt;
   logic [CODE_LEN-1:0] code_q;
   logic                take;
   logic                chip_vld;
   logic signed [IN_W-1:0] chip_i, chip_q;
   logic                met_vld;
   logic [IDX_W-1:0]    met_idx;
   logic [MET_W-1:0]    metric;
   logic [IDX_W-1:0]    rd_idx;
   logic [ACC_W-1:0]    rd_val;
   logic                scan_last;

   assign take = in_vld && (state == ST_RUN) && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         scnt   <= '0;
         fcnt   <= '0;
         code_q <= '0;
      end else begin
         if (code_we) code_q <= code_in;
         if (start) begin
            state <= ST_RUN;
            scnt  <= '0;
            fcnt  <= '0;
         end else begin
            unique case (state)
               ST_RUN: begin
                  if (take) begin
                     if (scnt == CNT_LAST) begin
                        state <= ST_FLUSH;
                        fcnt  <= '0;
                     end else begin
                        scnt <= scnt + 1'b1;
                     end
                  end
               end
               ST_FLUSH: begin
                  if (fcnt == FLUSH_LAST) state <= ST_SCAN;
                  else                    fcnt  <= fcnt + 1'b1;
               end
               ST_SCAN: begin
                  if (scan_last) state <= ST_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   sts_decim #(.SPC(SPC), .IN_W(IN_W)) u_decim (
      .clk(clk), .rst_n(rst_n), .clr(start), .take(take),
      .in_i(in_i), .in_q(in_q),
      .chip_vld(chip_vld), .chip_i(chip_i), .chip_q(chip_q)
   );

   sts_corr #(
      .IN_W(IN_W), .CODE_LEN(CODE_LEN), .SLOT_LEN(SLOT_LEN),
      .CORR_W(CORR_W), .MET_W(MET_W), .IDX_W(IDX_W)
   ) u_corr (
      .clk(clk), .rst_n(rst_n), .clr(start),
      .chip_vld(chip_vld), .chip_i(chip_i), .chip_q(chip_q), .code(code_q),
      .met_vld(met_vld), .met_idx(met_idx), .metric(metric)
   );

   sts_accum #(
      .SLOT_LEN(SLOT_LEN), .MET_W(MET_W), .ACC_W(ACC_W), .IDX_W(IDX_W)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .clr(start),
      .wr_en(met_vld), .wr_idx(met_idx), .wr_val(metric),
      .rd_idx(rd_idx), .rd_val(rd_val)
   );

   sts_peak #(
      .SLOT_LEN(SLOT_LEN), .ACC_W(ACC_W), .IDX_W(IDX_W)
   ) u_peak (
      .clk(clk), .rst_n(rst_n), .clr(start), .en(state == ST_SCAN),
      .rd_val(rd_val), .rd_idx(rd_idx), .last(scan_last),
      .res_vld(res_vld), .res_idx(res_idx)
   );

endmodule

// File: rtl/sts_chk.sv
`timescale 1ns/1ps
module sts_chk
   import slot_sync_pkg::*;
#(
   parameter int SPC      = 4,
   parameter int SLOT_LEN = 2560,
   parameter int IDX_W    = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             res_vld,
   input logic [IDX_W-1:0] res_idx,
   input sts_state_e       state,
   input logic             chip_vld,
   input logic             met_vld
);

   AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> !res_vld) else $error("result strobe longer than one cycle"); // R9

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (res_idx < IDX_W'(SLOT_LEN))) else $error("result index out of slot"); // R8

   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !res_vld) else $error("result after restart"); // R2

   AST_IDLE_NO_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> !chip_vld) else $error("chip produced while idle"); // R3

   AST_RES_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> ($past(state) == ST_SCAN)) else $error("result outside scan"); // R7

   AST_SCAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SCAN) |-> !met_vld) else $error("bin write during scan"); // R7

   generate
      if (SPC > 1) begin : g_decim_chk
         AST_DECIM_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            chip_vld |=> !chip_vld) else $error("chips closer than one group"); // R4
      end
   endgenerate

endmodule

bind slot_timing_sync sts_chk #(
   .SPC(SPC), .SLOT_LEN(SLOT_LEN), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .res_vld(res_vld), .res_idx(res_idx),
   .state(state), .chip_vld(chip_vld), .met_vld(met_vld)
);

// File: tb/sim_slot_timing_sync.sv
`timescale 1ns/1ps
module sim_slot_timing_sync;

   localparam int SPC   = 3;
   localparam int NSLOT = 3;
   localparam int S     = 40;
   localparam int CL    = 8;
   localparam int IN_W  = 12;
   localparam int IDX_W = $clog2(S);
   localparam int TOTAL = NSLOT * SPC * S;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic code_we = 1'b0;
   logic [CL-1:0] code_in = '0;
   logic in_vld = 1'b0;
   logic signed [IN_W-1:0] in_i = '0;
   logic signed [IN_W-1:0] in_q = '0;
   logic res_vld;
   logic [IDX_W-1:0] res_idx;

   always #2.5 clk = ~clk;

   slot_timing_sync #(
      .SPC(SPC), .NSLOT(NSLOT), .NSLOT_MAX(500), .SLOT_LEN(S),
      .CODE_LEN(CL), .IN_W(IN_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .code_we(code_we),
      .code_in(code_in), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
      .res_vld(res_vld), .res_idx(res_idx)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   // behavioural reference state
   bit          m_run = 0;
   int          m_phase = 0;
   int          m_cnt = 0;
   int          chi[$];
   int          chq[$];
   bit [CL-1:0] m_code = '0;
   int          exp_cyc = -1;
   int          exp_idx = 0;
   int unsigned rng = 32'h1234_5678;
   string       cur_req = "R6";

   function automatic int rnd(input int span);
      rng = rng * 32'd1103515245 + 32'd12345;
      return int'((rng >> 8) % span);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
      end
   endtask

   function automatic int model_peak();
      longint acc[S];
      int best;
      for (int o = 0; o < S; o++) acc[o] = 0;
      for (int k = 0; k < chi.size(); k++) begin
         longint si = 0, sq = 0;
         int o;
         for (int j = 0; j < CL; j++) begin
            int x = k - CL + 1 + j;
            if (x >= 0) begin
               si += m_code[j] ? chi[x] : -chi[x];
               sq += m_code[j] ? chq[x] : -chq[x];
            end
         end
         o = ((k - (CL - 1)) % S + S) % S;
         acc[o] += (si < 0 ? -si : si) + (sq < 0 ? -sq : sq);
      end
      best = 0;
      for (int o = 1; o < S; o++) if (acc[o] > acc[best]) best = o;
      return best;
   endfunction

   task automatic step(input bit st, input bit cw, input logic [CL-1:0] cv,
                       input bit v, input int si, input int sq);
      @(negedge clk);
      cyc++;
      // result strobe exactly where R7 / R9 place it
      check(res_vld == (cyc == exp_cyc), "R7/R9 strobe", longint'(res_vld), longint'(cyc == exp_cyc));
      if (cyc == exp_cyc)
         check(res_idx == IDX_W'(exp_idx), {cur_req, "/R8 index"}, longint'(res_idx), longint'(exp_idx));
      start   = st;
      code_we = cw;
      code_in = cv;
      in_vld  = v;
      in_i    = IN_W'(si);
      in_q    = IN_W'(sq);
      if (cw) m_code = cv;
      if (st) begin
         m_run = 1; m_phase = 0; m_cnt = 0;
         chi.delete(); chq.delete();
         if (exp_cyc > cyc) exp_cyc = -1;
      end else if (v && m_run) begin
         if (m_phase == 0) begin
            chi.push_back(si);
            chq.push_back(sq);
         end
         m_phase = (m_phase + 1) % SPC;
         m_cnt++;
         if (m_cnt == TOTAL) begin
            m_run   = 0;
            exp_idx = model_peak();
            exp_cyc = cyc + S + 3;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, 0);
   endtask

   function automatic int clampv(input int v);
      return (v > 2047) ? 2047 : ((v < -2048) ? -2048 : v);
   endfunction

   // feeds nsamp samples of a stream whose code starts at chip 'off' of each slot
   task automatic feed(input int off, input int amp, input int noise,
                       input bit gaps, input int nsamp, input bit zero);
      for (int s = 0; s < nsamp; s++) begin
         int k = s / SPC;
         int vi, vq;
         if (gaps) while (rnd(3) == 0) step(0, 0, '0, 0, rnd(4000) - 2000, 0);
         if (zero) begin
            vi = 0; vq = 0;
         end else if ((s % SPC) != 0) begin
            vi = rnd(4096) - 2048; vq = rnd(4096) - 2048;
         end else begin
            int d = ((k % S) - off + S) % S;
            vi = (noise > 0) ? rnd(2 * noise + 1) - noise : 0;
            vq = (noise > 0) ? rnd(2 * noise + 1) - noise : 0;
            if (d < CL) begin
               vi += m_code[d] ? amp : -amp;
               vq += m_code[d] ? -(amp / 2) : (amp / 2);
            end
            vi = clampv(vi); vq = clampv(vq);
         end
         step(0, 0, '0, 1, vi, vq);
      end
   endtask

   task automatic search(input string req, input int off, input int amp, input int noise,
                         input bit gaps, input bit zero);
      cur_req = req;
      step(1, 0, '0, 1, 1999, -1999);   // sample alongside start is dropped (R2)
      feed(off, amp, noise, gaps, TOTAL, zero);
      idle(S + 6);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(res_vld == 1'b0, "R1 reset", longint'(res_vld), 0);
      rst_n = 1'b1;
      idle(4);
      check(res_vld == 1'b0, "R1 idle after reset", longint'(res_vld), 0);

      // R5: code load, bit 0 is the first chip
      step(0, 1, 8'b1011_0010, 0, 0, 0);
      // R3: samples while idle are not taken
      for (int i = 0; i < 20; i++) step(0, 0, '0, 1, 2000, -2000);
      idle(S + 6);

      search("R6", 13, 300, 100, 0, 0);
      search("R4", 37, 500, 150, 1, 0);     // wraps across slot end, gapped input
      step(0, 1, 8'b0110_1001, 0, 0, 0);    // R5: new code
      search("R5", 5, 400, 80, 0, 0);
      search("R8", 0, 0, 0, 0, 1);          // all zero: tie resolves to bin 0
      search("R10", 0, 2048, 0, 0, 0);      // full-scale input

      // R2: abort mid-search, restart, then a full search
      cur_req = "R2";
      step(1, 0, '0, 0, 0, 0);
      feed(21, 600, 50, 0, TOTAL - 5, 0);
      search("R2", 25, 350, 100, 1, 0);

      // R9: extra samples after the result produce nothing
      for (int i = 0; i < 30; i++) step(0, 0, '0, 1, 1000, 1000);
      idle(S + 6);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule